// File: doc/BRIEF.md
# Instruction Fetch Wait-State Controller

This block sits between the instruction-fetch port of a pipelined processor and a simple synchronous instruction memory. In the cycle before the processor wants an instruction, it drives an active-low request strobe, a flag that says whether the fetch follows on from the previous one, and a halfword-aligned address. The controller samples these at the end of that cycle and starts the memory read at the same edge. It then classes the fetch. A fetch that jumps to a new address is held for a configurable number of extra cycles using an active-high wait output. A fetch that follows on from the previous address completes in its first cycle.

An instruction is delivered in the first fetch cycle in which wait is low. An abort flag comes with it, raised when the fetched byte address lies inside a configurable protected window. In that case the returned instruction word is forced to zero. Idle cycles and the unused code point start no memory access and leave the returned instruction and abort flag unchanged. The unused code point also sets a sticky error flag, which only reset clears.

Top module: `ifw_ctrl`

## Requirements
- R1: The two-bit code {req_n_i, seq_i} is decoded as 00 = jump (non-sequential) fetch, 01 = follow-on (sequential) fetch, 10 = idle, 11 = unused. The code is sampled only at a rising clock edge where wait_o is low, and the fetch cycle is the cycle after that edge.
- R2: An accepted jump fetch holds wait_o high for exactly WAIT_N cycles after the accepting edge. wait_o is then low in the completing cycle.
- R3: A follow-on fetch that is accepted at the edge ending the completing cycle of a previous fetch completes with wait_o low in its first fetch cycle.
- R4: A follow-on fetch is given the full WAIT_N wait cycles when the previously accepted code was idle or unused, or when it is the first fetch after reset.
- R5: While wait_o is high, the request inputs are ignored: mem_en_o stays low and no new fetch is accepted.
- R6: In the cycle a fetch is accepted, mem_en_o is high and mem_addr_o equals addr_i. This makes the memory read happen at the accepting edge.
- R7: For a completing fetch whose byte address {addr, 0} lies in [PROT_BASE, PROT_LIMIT], abort_o is high and instr_o is all zeros. Outside that window abort_o is low. Both have the same timing as the instruction.
- R8: For a completing fetch that is not aborted, instr_o equals the memory word at the fetched address.
- R9: An accepted idle or unused code starts no memory access. instr_o and abort_o keep their values in the following cycle.
- R10: An accepted unused code (11) sets rsvd_err_o from the next cycle on, and it stays set until reset.
- R11: With PROT_EN = 0, abort_o stays low at all times and instructions are returned unmasked.
- R12: While reset is active and right after it, wait_o, abort_o and rsvd_err_o are low, and an idle bus gives mem_en_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_n_i | input | 1 | Fetch request strobe, active low, valid the cycle before the fetch |
| seq_i | input | 1 | Follow-on flag: 1 = address continues from the previous fetch |
| addr_i | input | ADDR_MSB | Halfword fetch address, bits ADDR_MSB down to 1 |
| wait_o | output | 1 | Stall to the processor, active high |
| instr_o | output | DATA_W | Returned instruction word (zero when aborted) |
| abort_o | output | 1 | Fetch abort, timed with instr_o |
| rsvd_err_o | output | 1 | Sticky flag: the unused cycle code was seen |
| mem_en_o | output | 1 | Read enable to the synchronous memory |
| mem_addr_o | output | ADDR_MSB | Read address to the memory, bits ADDR_MSB down to 1 |
| mem_rdata_i | input | DATA_W | Read data from the memory, one cycle after mem_en_o |

## Verification
The main function is driven with four patterns. An isolated jump fetch shows that the WAIT_N stall is exact. A chain of follow-on fetches placed directly after a completion separates the single-cycle path from the stalled one. Follow-on fetches placed after reset, after an idle cycle and after the unused code show that the chain is broken and the full stall returns. A new request held on the bus during a stall shows that nothing is taken until wait falls. Addresses at both edges of the protected window, and just outside it, pin down the abort boundary. An unprotected second instance on the same bus shows that the abort path is absent when the window is disabled.

// File: rtl/ifw_pkg.sv
`timescale 1ns/1ps
package ifw_pkg;
  // Cycle class; the encoding equals the {req_n, seq} bus code.
  typedef enum logic [1:0] {
    CYC_JUMP   = 2'b00,
    CYC_FOLLOW = 2'b01,
    CYC_IDLE   = 2'b10,
    CYC_UNUSED = 2'b11
  } cyc_t;
endpackage

// File: rtl/ifw_decode.sv
`timescale 1ns/1ps
module ifw_decode
  import ifw_pkg::*;
(
  input  logic req_n_i,
  input  logic seq_i,
  output cyc_t cyc_o
);
  always_comb begin
    unique case ({req_n_i, seq_i})
      2'b00:   cyc_o = CYC_JUMP;
      2'b01:   cyc_o = CYC_FOLLOW;
      2'b10:   cyc_o = CYC_IDLE;
      default: cyc_o = CYC_UNUSED;
    endcase
  end
endmodule

// File: rtl/ifw_wait_ctr.sv
`timescale 1ns/1ps
module ifw_wait_ctr #(
  parameter int WAIT_N = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic load_i,
  output logic busy_o
);
  localparam int CNT_W = $clog2(WAIT_N + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= CNT_W'(WAIT_N);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/ifw_prot_chk.sv
`timescale 1ns/1ps
module ifw_prot_chk #(
  parameter int               ADDR_MSB   = 31,
  parameter bit               PROT_EN    = 1'b0,
  parameter logic [ADDR_MSB:0] PROT_BASE  = '0,
  parameter logic [ADDR_MSB:0] PROT_LIMIT = '0
) (
  input  logic [ADDR_MSB:1] addr_i,
  output logic              hit_o
);
  logic [ADDR_MSB:0] byte_addr;

  always_comb begin
    byte_addr = {addr_i, 1'b0};
    hit_o     = PROT_EN && (byte_addr >= PROT_BASE) && (byte_addr <= PROT_LIMIT);
  end
endmodule

// File: rtl/ifw_ctrl.sv
`timescale 1ns/1ps
module ifw_ctrl
  import ifw_pkg::*;
#(
  parameter int               ADDR_MSB   = 31,
  parameter int               DATA_W     = 32,
  parameter int               WAIT_N     = 1,
  parameter bit               PROT_EN    = 1'b0,
  parameter logic [ADDR_MSB:0] PROT_BASE  = '0,
  parameter logic [ADDR_MSB:0] PROT_LIMIT = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_n_i,
  input  logic              seq_i,
  input  logic [ADDR_MSB:1] addr_i,
  output logic              wait_o,
  output logic [DATA_W-1:0] instr_o,
  output logic              abort_o,
  output logic              rsvd_err_o,
  output logic              mem_en_o,
  output logic [ADDR_MSB:1] mem_addr_o,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  cyc_t cyc;
  logic busy;
  logic accept;
  logic fetch_go;
  logic need_wait;
  logic prot_hit;
  logic chain_q;
  logic abort_q;
  logic err_q;

  ifw_decode u_dec (
    .req_n_i (req_n_i),
    .seq_i   (seq_i),
    .cyc_o   (cyc)
  );

  ifw_prot_chk #(
    .ADDR_MSB   (ADDR_MSB),
    .PROT_EN    (PROT_EN),
    .PROT_BASE  (PROT_BASE),
    .PROT_LIMIT (PROT_LIMIT)
  ) u_prot (
    .addr_i (addr_i),
    .hit_o  (prot_hit)
  );

  ifw_wait_ctr #(
    .WAIT_N (WAIT_N)
  ) u_wait (
    .clk    (clk),
    .rst    (rst),
    .load_i (need_wait),
    .busy_o (busy)
  );

  // The bus code is taken only when the processor is not being held.
  always_comb begin
    accept    = !busy;
    fetch_go  = accept && ((cyc == CYC_JUMP) || (cyc == CYC_FOLLOW));
    need_wait = fetch_go && ((cyc == CYC_JUMP) || !chain_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= 1'b0;
      abort_q <= 1'b0;
      err_q   <= 1'b0;
    end else if (accept) begin
      chain_q <= fetch_go;
      if (fetch_go) begin
        abort_q <= prot_hit;
      end
      if (cyc == CYC_UNUSED) begin
        err_q <= 1'b1;
      end
    end
  end

  assign mem_en_o   = fetch_go;
  assign mem_addr_o = addr_i;
  assign wait_o     = busy;
  assign abort_o    = abort_q;
  assign rsvd_err_o = err_q;
  assign instr_o    = abort_q ? '0 : mem_rdata_i;
endmodule

// File: rtl/ifw_ctrl_chk.sv
`timescale 1ns/1ps
module ifw_ctrl_chk #(
  parameter int DATA_W  = 32,
  parameter int WAIT_N  = 1,
  parameter bit PROT_EN = 1'b0
) (
  input logic              clk,
  input logic              rst,
  input logic              req_n_i,
  input logic              wait_o,
  input logic              mem_en_o,
  input logic              abort_o,
  input logic              rsvd_err_o,
  input logic [DATA_W-1:0] instr_o
);
  int wc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wc_q <= 0;
    end else begin
      wc_q <= wait_o ? wc_q + 1 : 0;
    end
  end

  a_r2_wait_max: assert property (@(posedge clk) disable iff (rst)
    wait_o |-> (wc_q < WAIT_N));

  a_r2_wait_full: assert property (@(posedge clk) disable iff (rst)
    $fell(wait_o) |-> (wc_q == WAIT_N));

  a_r5_no_mem_stall: assert property (@(posedge clk) disable iff (rst)
    wait_o |-> !mem_en_o);

  a_r9_idle_keeps: assert property (@(posedge clk) disable iff (rst)
    (!wait_o && req_n_i) |=> ($stable(instr_o) && $stable(abort_o)));

  a_r10_err_sticky: assert property (@(posedge clk) disable iff (rst)
    rsvd_err_o |=> rsvd_err_o);

  generate
    if (!PROT_EN) begin : g_noprot
      a_r11_no_abort: assert property (@(posedge clk) disable iff (rst)
        !abort_o);
    end
  endgenerate
endmodule

bind ifw_ctrl ifw_ctrl_chk #(
  .DATA_W  (DATA_W),
  .WAIT_N  (WAIT_N),
  .PROT_EN (PROT_EN)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_n_i    (req_n_i),
  .wait_o     (wait_o),
  .mem_en_o   (mem_en_o),
  .abort_o    (abort_o),
  .rsvd_err_o (rsvd_err_o),
  .instr_o    (instr_o)
);

// File: tb/ifw_ctrl_tb_top.sv
`timescale 1ns/1ps
module ifw_ctrl_tb_top;
  localparam int          WAIT_N = 2;
  localparam logic [31:0] BASE   = 32'h0000_0400;
  localparam logic [31:0] LIMIT  = 32'h0000_04FF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_n = 1'b1;
  logic        seq = 1'b0;
  logic [31:1] addr = '0;
  logic [31:0] mem_rdata = '0;

  logic        wait_o, abort_o, err_o, mem_en;
  logic [31:0] instr_o;
  logic [31:1] mem_addr;
  logic        wait_np, abort_np, err_np, mem_en_np;
  logic [31:0] instr_np;
  logic [31:1] mem_addr_np;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  ifw_ctrl #(
    .WAIT_N (WAIT_N), .PROT_EN (1'b1), .PROT_BASE (BASE), .PROT_LIMIT (LIMIT)
  ) dut_i (
    .clk (clk), .rst (rst), .req_n_i (req_n), .seq_i (seq), .addr_i (addr),
    .wait_o (wait_o), .instr_o (instr_o), .abort_o (abort_o),
    .rsvd_err_o (err_o), .mem_en_o (mem_en), .mem_addr_o (mem_addr),
    .mem_rdata_i (mem_rdata)
  );

  ifw_ctrl #(
    .WAIT_N (WAIT_N), .PROT_EN (1'b0), .PROT_BASE (BASE), .PROT_LIMIT (LIMIT)
  ) dut_np_i (
    .clk (clk), .rst (rst), .req_n_i (req_n), .seq_i (seq), .addr_i (addr),
    .wait_o (wait_np), .instr_o (instr_np), .abort_o (abort_np),
    .rsvd_err_o (err_np), .mem_en_o (mem_en_np), .mem_addr_o (mem_addr_np),
    .mem_rdata_i (mem_rdata)
  );

  function automatic logic [31:0] mem_word(input logic [31:0] b);
    return {b[16:1], ~b[16:1]} ^ 32'h5A5A_0F0F;
  endfunction

  function automatic bit in_prot(input logic [31:0] b);
    return (b >= BASE) && (b <= LIMIT);
  endfunction

  // Synchronous instruction memory, one cycle read latency.
  always @(posedge clk) begin
    if (mem_en) mem_rdata <= mem_word({mem_addr, 1'b0});
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // Called at a negedge with wait_o low: drive a request, check the memory port.
  task automatic present(input logic [31:0] b, input bit s);
    req_n = 1'b0;
    seq   = s;
    addr  = b[31:1];
    #1;
    check(mem_en == 1'b1, "R6", "mem_en on accept", {31'd0, mem_en}, 32'd1);
    check(mem_addr == b[31:1], "R6", "mem_addr on accept", {1'b0, mem_addr}, {1'b0, b[31:1]});
  endtask

  // Wait for completion, then check stall length, data and abort.
  task automatic collect(input logic [31:0] b, input int exp_nw, input string req);
    int n;
    logic [31:0] exp_d;
    @(negedge clk);
    req_n = 1'b1;
    seq   = 1'b0;
    n = 0;
    while (wait_o && n < 64) begin
      n++;
      @(negedge clk);
    end
    check(n == exp_nw, req, "wait cycles", n, exp_nw);
    exp_d = in_prot(b) ? 32'd0 : mem_word(b);
    check(instr_o == exp_d, in_prot(b) ? "R7" : "R8", "instr", instr_o, exp_d);
    check(abort_o == in_prot(b), "R7", "abort", {31'd0, abort_o}, {31'd0, in_prot(b)});
    check(abort_np == 1'b0, "R11", "abort unprotected", {31'd0, abort_np}, 32'd0);
    check(instr_np == mem_word(b), "R11", "instr unprotected", instr_np, mem_word(b));
  endtask

  task automatic t_reset();
    rst = 1'b1;
    req_n = 1'b1;
    seq = 1'b0;
    repeat (3) @(negedge clk);
    check(wait_o == 1'b0 && abort_o == 1'b0 && err_o == 1'b0, "R12", "outputs in reset",
          {29'd0, wait_o, abort_o, err_o}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check(wait_o == 1'b0 && abort_o == 1'b0 && err_o == 1'b0 && mem_en == 1'b0, "R12",
          "outputs after reset", {28'd0, wait_o, abort_o, err_o, mem_en}, 32'd0);
  endtask

  task automatic t_seq_after_reset();
    present(32'h0000_0100, 1'b1);
    collect(32'h0000_0100, WAIT_N, "R4 follow-on after reset");
  endtask

  task automatic t_jump();
    present(32'h0000_0222, 1'b0);
    collect(32'h0000_0222, WAIT_N, "R1 R2 jump");
    @(negedge clk);
    present(32'h0000_0876, 1'b0);
    collect(32'h0000_0876, WAIT_N, "R2 second jump");
  endtask

  task automatic t_follow_chain();
    present(32'h0000_0300, 1'b0);
    collect(32'h0000_0300, WAIT_N, "R2 chain head");
    present(32'h0000_0302, 1'b1);
    collect(32'h0000_0302, 0, "R1 R3 follow-on");
    present(32'h0000_0304, 1'b1);
    collect(32'h0000_0304, 0, "R3 follow-on");
    present(32'h0000_0380, 1'b0);
    collect(32'h0000_0380, WAIT_N, "R2 jump inside chain");
  endtask

  task automatic t_follow_after_idle();
    @(negedge clk);
    present(32'h0000_0382, 1'b1);
    collect(32'h0000_0382, WAIT_N, "R4 follow-on after idle");
  endtask

  task automatic t_stall_ignore();
    int n;
    present(32'h0000_0500, 1'b0);
    @(negedge clk);
    req_n = 1'b0;
    seq   = 1'b1;
    addr  = 31'h0000_0281;
    n = 0;
    while (wait_o && n < 64) begin
      #1;
      check(mem_en == 1'b0, "R5", "mem_en during stall", {31'd0, mem_en}, 32'd0);
      n++;
      @(negedge clk);
    end
    check(n == WAIT_N, "R5", "stall length with held request", n, WAIT_N);
    check(instr_o == mem_word(32'h0000_0500), "R5", "instr of first fetch",
          instr_o, mem_word(32'h0000_0500));
    #1;
    check(mem_en == 1'b1 && mem_addr == 31'h0000_0281, "R6", "held request taken at completion",
          {mem_en, mem_addr}, {1'b1, 31'h0000_0281});
    collect(32'h0000_0502, 0, "R3 follow-on after stall");
  endtask

  task automatic t_abort();
    present(32'h0000_0400, 1'b0);
    collect(32'h0000_0400, WAIT_N, "R7 window base");
    @(negedge clk);
    present(32'h0000_03FE, 1'b0);
    collect(32'h0000_03FE, WAIT_N, "R7 below window");
    @(negedge clk);
    present(32'h0000_04FE, 1'b0);
    collect(32'h0000_04FE, WAIT_N, "R7 window top");
    present(32'h0000_0500, 1'b1);
    collect(32'h0000_0500, 0, "R7 follow-on leaves window");
    present(32'h0000_0480, 1'b0);
    collect(32'h0000_0480, WAIT_N, "R7 window middle");
  endtask

  task automatic t_idle_hold();
    logic [31:0] d0;
    logic        a0;
    d0 = instr_o;
    a0 = abort_o;
    repeat (3) begin
      @(negedge clk);
      check(mem_en == 1'b0, "R9", "no access on idle", {31'd0, mem_en}, 32'd0);
      check(instr_o == d0, "R9", "instr held on idle", instr_o, d0);
      check(abort_o == a0, "R9", "abort held on idle", {31'd0, abort_o}, {31'd0, a0});
    end
  endtask

  task automatic t_unused_code();
    logic [31:0] d0;
    d0 = instr_o;
    check(err_o == 1'b0, "R10", "error flag before unused code", {31'd0, err_o}, 32'd0);
    req_n = 1'b1;
    seq   = 1'b1;
    #1;
    check(mem_en == 1'b0, "R9", "no access on unused code", {31'd0, mem_en}, 32'd0);
    @(negedge clk);
    seq = 1'b0;
    check(err_o == 1'b1, "R10", "error flag set", {31'd0, err_o}, 32'd1);
    check(instr_o == d0, "R9", "instr held on unused code", instr_o, d0);
    repeat (3) @(negedge clk);
    check(err_o == 1'b1, "R10", "error flag sticky", {31'd0, err_o}, 32'd1);
    req_n = 1'b1;
    seq   = 1'b1;
    @(negedge clk);
    present(32'h0000_0600, 1'b1);
    collect(32'h0000_0600, WAIT_N, "R4 follow-on after unused code");
    check(err_o == 1'b1, "R10", "error flag still set", {31'd0, err_o}, 32'd1);
  endtask

  task automatic t_reset_clears();
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(err_o == 1'b0 && abort_o == 1'b0 && wait_o == 1'b0, "R12", "reset clears flags",
          {29'd0, err_o, abort_o, wait_o}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #600000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_seq_after_reset();
    t_jump();
    t_follow_chain();
    t_follow_after_idle();
    t_stall_ignore();
    t_abort();
    t_idle_hold();
    t_unused_code();
    t_idle_hold();
    t_reset_clears();
    summary();
    $finish;
  end
endmodule